// File: doc/BRIEF.md
# Masked I2C Slave Address Matcher

This block decides whether an I2C slave should answer, given the address bytes that a bit-level receiver hands it one at a time. It handles both 7-bit and 10-bit addressing. A programmable mask marks chosen address bits as don't-care, so one slave can answer a whole group of addresses. The receiver supplies each byte with a one-cycle strobe, plus one-cycle indications of start (or repeated start) and stop conditions. Bit sampling on the bus lines, acknowledge driving and data transfer belong to other blocks.

Software programs two registers through a small write port: the address location and the upper-address location. The mask has no location of its own. It is reached through the address location only while the mode field holds the mask-access code. The matcher reports a one-cycle match pulse, a flag showing that the upper byte of a 10-bit address has matched, and the direction bit taken from the address that matched.

Top module: `slv_addr_filter`

## Requirements
- R1: After reset, the mask holds 8'hFF, the address and upper-address registers hold 0, and `matchPulse`, `hiMatched` and `rwBit` are 0.
- R2: In 7-bit mode (`modeSel`=4'b0110), a received address byte matches when every bit 7:1 whose mask bit is 1 equals the same bit of the address register. Bits whose mask bit is 0 are ignored.
- R3: In 7-bit mode, received bit 0 is never compared, and mask bit 0 has no effect. On a match, `rwBit` takes received bit 0.
- R4: In 10-bit mode (`modeSel`=4'b0111), the low address byte matches when every bit 7:0 whose mask bit is 1 equals the address register. A mismatch clears `hiMatched`.
- R5: In 10-bit mode, the first byte after a start matches only if bits 7:3 are 5'b11110 and bits 2:1 equal bits 2:1 of the upper-address register. The mask never affects this comparison. A match with bit 0 equal to 0 sets `hiMatched` and makes the next byte the low address byte. A mismatch clears `hiMatched`.
- R6: While `modeSel`=4'b1001, writes and reads at the address location (`regSel`=0) reach the mask. In any other mode they reach the address register, and the mask is unchanged.
- R7: `matchPulse` is high for exactly one cycle: the cycle after the strobe of the byte that completes a match.
- R8: A stop indication clears `hiMatched`.
- R9: In 10-bit mode, when `hiMatched` is set, a repeated start followed by a matching upper byte with bit 0 equal to 1 gives a match with `rwBit`=1. Without `hiMatched` set, the same byte gives no match.
- R10: Only the first byte after a start, or the byte after a matched 10-bit upper byte written with bit 0 equal to 0, is taken as an address. Later bytes never raise a match.
- R11: In any mode other than 4'b0110 and 4'b0111, no byte raises a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 4 | Mode field: 0110 selects 7-bit slave, 0111 selects 10-bit slave, 1001 selects mask access |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the address location, 1 selects the upper-address location |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Contents of the selected location |
| startSeen | input | 1 | One-cycle pulse on a start or repeated start |
| stopSeen | input | 1 | One-cycle pulse on a stop |
| byteValid | input | 1 | One-cycle strobe marking a received byte |
| rxByte | input | 8 | Received byte, with the bit sent first in bit 7 |
| matchPulse | output | 1 | One-cycle pulse on an address match |
| hiMatched | output | 1 | The 10-bit upper byte has matched |
| rwBit | output | 1 | Direction bit of the last matched address |

## Verification
The hardest state to reach is the 10-bit read path. The bench must first match an upper byte written with bit 0 equal to 0, then match the low byte, then send a repeated start with no stop in between, and only then send the read upper byte. A stop anywhere in that sequence resets the path. Directed sequences walk this path, and a second read is then tried after a stop to confirm that it is refused. Random mask and address values are mixed with received bytes built by flipping only masked-off bits, so that matches occur often rather than one time in 128.

// File: rtl/slv_addr_pkg.sv
package slv_addr_pkg;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_SEVEN   = 4'b0110;
  localparam logic [MODE_W-1:0] MODE_TEN     = 4'b0111;
  localparam logic [MODE_W-1:0] MODE_MASKACC = 4'b1001;
  localparam logic [4:0]        TEN_PREFIX   = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LOW,
    ST_DATA
  } ctrlState_t;

  typedef struct packed {
    logic fire;
    logic takeRw;
    logic rwVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/slv_addr_dp.sv
module slv_addr_dp
  import slv_addr_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         regSel,
  input  logic [W-1:0] regWrData,
  input  logic         maskAccess,
  input  logic [W-1:0] rxByte,
  input  ctrlStrobe_t  strobe,
  output logic [W-1:0] regRdData,
  output logic [W-1:0] maskVal,
  output logic         hit7,
  output logic         hitHi,
  output logic         hitLow,
  output logic         matchPulse,
  output logic         rwBit
);
  localparam int PFX_W = W - 3;

  logic [W-1:0] addrQ, hiQ, maskQ;
  logic [W-1:0] diff, mask7;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      hiQ   <= '0;
      maskQ <= '1;
    end else if (regWrEn) begin
      if (regSel)          hiQ   <= regWrData;
      else if (maskAccess) maskQ <= regWrData;
      else                 addrQ <= regWrData;
    end
  end

  always_comb begin
    if (regSel)          regRdData = hiQ;
    else if (maskAccess) regRdData = maskQ;
    else                 regRdData = addrQ;
  end

  assign diff    = rxByte ^ addrQ;
  assign mask7   = {maskQ[W-1:1], 1'b0};
  assign hit7    = ((diff & mask7) == '0);
  assign hitLow  = ((diff & maskQ) == '0);
  assign hitHi   = (rxByte[W-1:3] == TEN_PREFIX[PFX_W-1:0]) && (rxByte[2:1] == hiQ[2:1]);
  assign maskVal = maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchPulse <= 1'b0;
      rwBit      <= 1'b0;
    end else begin
      matchPulse <= strobe.fire;
      if (strobe.takeRw) rwBit <= strobe.rwVal;
    end
  end
endmodule

// File: rtl/slv_addr_ctrl.sv
module slv_addr_ctrl
  import slv_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              byteValid,
  input  logic              rxBit0,
  input  logic              hit7,
  input  logic              hitHi,
  input  logic              hitLow,
  output ctrlStrobe_t       strobe,
  output logic              hiMatched
);
  ctrlState_t state, nextState;
  logic       hiQ, nextHi;

  always_comb begin
    nextState = state;
    nextHi    = hiQ;
    strobe    = '0;
    if (stopSeen) begin
      nextState = ST_IDLE;
      nextHi    = 1'b0;
    end else if (startSeen) begin
      nextState = ST_ADDR;
    end else if (byteValid) begin
      case (state)
        ST_ADDR: begin
          nextState = ST_DATA;
          if (modeSel == MODE_SEVEN) begin
            if (hit7) begin
              strobe.fire   = 1'b1;
              strobe.takeRw = 1'b1;
              strobe.rwVal  = rxBit0;
            end
          end else if (modeSel == MODE_TEN) begin
            if (!hitHi) begin
              nextHi = 1'b0;
            end else if (!rxBit0) begin
              nextHi        = 1'b1;
              nextState     = ST_LOW;
              strobe.takeRw = 1'b1;
            end else if (hiQ) begin
              strobe.fire   = 1'b1;
              strobe.takeRw = 1'b1;
              strobe.rwVal  = 1'b1;
            end
          end
        end
        ST_LOW: begin
          nextState = ST_DATA;
          if (modeSel == MODE_TEN && hitLow) begin
            strobe.fire   = 1'b1;
            strobe.takeRw = 1'b1;
          end else begin
            nextHi = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      hiQ   <= 1'b0;
    end else begin
      state <= nextState;
      hiQ   <= nextHi;
    end
  end

  assign hiMatched = hiQ;
endmodule

// File: rtl/slv_addr_filter.sv
module slv_addr_filter
  import slv_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              matchPulse,
  output logic              hiMatched,
  output logic              rwBit
);
  ctrlStrobe_t       strobe;
  logic              hit7, hitHi, hitLow;
  logic [BYTE_W-1:0] maskVal;

  slv_addr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .startSeen(startSeen), .stopSeen(stopSeen), .byteValid(byteValid),
    .rxBit0(rxByte[0]), .hit7(hit7), .hitHi(hitHi), .hitLow(hitLow),
    .strobe(strobe), .hiMatched(hiMatched)
  );

  slv_addr_dp #(.W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .maskAccess(modeSel == MODE_MASKACC),
    .rxByte(rxByte), .strobe(strobe), .regRdData(regRdData),
    .maskVal(maskVal), .hit7(hit7), .hitHi(hitHi), .hitLow(hitLow),
    .matchPulse(matchPulse), .rwBit(rwBit)
  );
endmodule

// File: rtl/slv_addr_filter_chk.sv
module slv_addr_filter_chk
  import slv_addr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] modeSel,
  input logic              regWrEn,
  input logic              regSel,
  input logic              byteValid,
  input logic              stopSeen,
  input logic              matchPulse,
  input logic              hiMatched,
  input logic [BYTE_W-1:0] maskVal
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse); // R7
  AST_PULSE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(byteValid)); // R7
  AST_STOP_DROPS_HI: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !hiMatched); // R8
  AST_MASK_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && modeSel != MODE_MASKACC) |=> $stable(maskVal)); // R6
  AST_SLAVE_MODE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> ($past(modeSel) == MODE_SEVEN || $past(modeSel) == MODE_TEN)); // R11
  AST_HI_TEN_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiMatched) |-> ($past(modeSel) == MODE_TEN && $past(byteValid))); // R5
endmodule

bind slv_addr_filter slv_addr_filter_chk chk_i (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .regWrEn(regWrEn),
  .regSel(regSel), .byteValid(byteValid), .stopSeen(stopSeen),
  .matchPulse(matchPulse), .hiMatched(hiMatched), .maskVal(maskVal)
);

// File: tb/slv_addr_filter_tb.sv
module slv_addr_filter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] modeSel = 4'b0000;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       startSeen = 1'b0;
  logic       stopSeen = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic       matchPulse, hiMatched, rwBit;

  int checks = 0;
  int errors = 0;
  logic [7:0] mAddr, mHi, mMask;

  localparam logic [3:0] M7 = 4'b0110, M10 = 4'b0111, MK = 4'b1001;

  always #10 clk = ~clk;

  slv_addr_filter dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .startSeen(startSeen), .stopSeen(stopSeen), .byteValid(byteValid),
    .rxByte(rxByte), .matchPulse(matchPulse), .hiMatched(hiMatched),
    .rwBit(rwBit)
  );

  function automatic logic exp7(input logic [7:0] rx, input logic [7:0] a, input logic [7:0] m);
    return ((rx ^ a) & m & 8'hFE) == 8'h00;
  endfunction

  function automatic logic expLow(input logic [7:0] rx, input logic [7:0] a, input logic [7:0] m);
    return ((rx ^ a) & m) == 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] mode, input logic sel, input logic [7:0] d);
    @(negedge clk);
    modeSel = mode; regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (sel) mHi = d;
    else if (mode == MK) mMask = d;
    else mAddr = d;
  endtask

  task automatic readReg(input string req, input logic [3:0] mode, input logic sel, input logic [7:0] exp);
    @(negedge clk);
    modeSel = mode; regSel = sel;
    #1 chk(req, regRdData, exp);
  endtask

  task automatic pulseStart();
    @(negedge clk); startSeen = 1'b1;
    @(negedge clk); startSeen = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopSeen = 1'b1;
    @(negedge clk); stopSeen = 1'b0;
  endtask

  task automatic sendByte(input string req, input logic [7:0] b, input logic expFire, input logic expRw);
    @(negedge clk); rxByte = b; byteValid = 1'b1;
    @(negedge clk); byteValid = 1'b0;
    chk(req, {7'd0, matchPulse}, {7'd0, expFire});
    if (expFire) chk(req, {7'd0, rwBit}, {7'd0, expRw});
    @(negedge clk);
    chk("R7 pulse width", {7'd0, matchPulse}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    void'($urandom(32'h5EED1234));
    mAddr = 8'h00; mHi = 8'h00; mMask = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 matchPulse", {7'd0, matchPulse}, 8'd0);
    chk("R1 hiMatched", {7'd0, hiMatched}, 8'd0);
    chk("R1 rwBit", {7'd0, rwBit}, 8'd0);
    readReg("R1 mask", MK, 1'b0, 8'hFF);
    readReg("R1 addr", M7, 1'b0, 8'h00);
    readReg("R1 hi", M7, 1'b1, 8'h00);

    // R6 redirection
    writeReg(M7, 1'b0, 8'hA4);
    readReg("R6 mask untouched", MK, 1'b0, 8'hFF);
    writeReg(MK, 1'b0, 8'hF1);
    readReg("R6 mask written", MK, 1'b0, 8'hF1);
    readReg("R6 addr kept", M7, 1'b0, 8'hA4);

    // R2/R3 with mask F1: bits 3:1 don't care, bit 0 ignored
    pulseStart();
    sendByte("R2 masked bits", 8'hAB, 1'b1, 1'b1);
    sendByte("R10 data byte", 8'hA4, 1'b0, 1'b0);
    pulseStop();
    pulseStart();
    sendByte("R2 compared bit", 8'hB4, 1'b0, 1'b0);
    pulseStop();
    writeReg(MK, 1'b0, 8'hFF);
    modeSel = M7;
    pulseStart();
    sendByte("R3 bit0 read", 8'hA5, 1'b1, 1'b1);
    pulseStop();
    pulseStart();
    sendByte("R3 bit0 write", 8'hA4, 1'b1, 1'b0);
    pulseStop();

    // random 7-bit
    for (int i = 0; i < 120; i++) begin
      writeReg(MK, 1'b0, 8'($urandom));
      writeReg(M7, 1'b0, 8'($urandom));
      rx = ($urandom % 2) ? 8'($urandom) : (mAddr ^ (8'($urandom) & ~mMask));
      pulseStart();
      sendByte("R2 random", rx, exp7(rx, mAddr, mMask), rx[0]);
      pulseStop();
    end

    // R11 other modes
    writeReg(MK, 1'b0, 8'hFF);
    writeReg(M7, 1'b0, 8'h52);
    modeSel = 4'b0000;
    pulseStart();
    sendByte("R11 mode 0000", 8'h52, 1'b0, 1'b0);
    pulseStop();
    modeSel = MK;
    pulseStart();
    sendByte("R11 mode 1001", 8'h52, 1'b0, 1'b0);
    pulseStop();

    // 10-bit directed
    writeReg(M10, 1'b1, 8'hF4);
    writeReg(M10, 1'b0, 8'h3C);
    pulseStart();
    sendByte("R5 hi byte", 8'hF4, 1'b0, 1'b0);
    chk("R5 hiMatched set", {7'd0, hiMatched}, 8'd1);
    sendByte("R4 low byte", 8'h3C, 1'b1, 1'b0);
    sendByte("R10 data after low", 8'hF5, 1'b0, 1'b0);
    chk("R9 hi held", {7'd0, hiMatched}, 8'd1);
    pulseStart();
    sendByte("R9 read match", 8'hF5, 1'b1, 1'b1);
    pulseStop();
    chk("R8 stop clears", {7'd0, hiMatched}, 8'd0);
    pulseStart();
    sendByte("R9 read refused", 8'hF5, 1'b0, 1'b0);
    pulseStop();
    writeReg(MK, 1'b0, 8'h00);
    modeSel = M10;
    pulseStart();
    sendByte("R5 mask ignored on hi", 8'hF6, 1'b0, 1'b0);
    chk("R5 hiMatched clear", {7'd0, hiMatched}, 8'd0);
    pulseStop();
    pulseStart();
    sendByte("R5 hi byte", 8'hF4, 1'b0, 1'b0);
    sendByte("R4 all dont care", 8'h00, 1'b1, 1'b0);
    pulseStop();
    writeReg(MK, 1'b0, 8'hFE);
    modeSel = M10;
    pulseStart();
    sendByte("R5 hi byte", 8'hF4, 1'b0, 1'b0);
    sendByte("R4 bit0 dont care", 8'h3D, 1'b1, 1'b0);
    pulseStop();
    writeReg(MK, 1'b0, 8'hFF);
    modeSel = M10;
    pulseStart();
    sendByte("R5 hi byte", 8'hF4, 1'b0, 1'b0);
    sendByte("R4 bit0 compared", 8'h3D, 1'b0, 1'b0);
    chk("R4 mismatch clears hi", {7'd0, hiMatched}, 8'd0);
    pulseStop();

    // random 10-bit low byte
    for (int i = 0; i < 100; i++) begin
      writeReg(MK, 1'b0, 8'($urandom));
      writeReg(M10, 1'b0, 8'($urandom));
      rx = ($urandom % 2) ? 8'($urandom) : (mAddr ^ (8'($urandom) & ~mMask));
      pulseStart();
      sendByte("R5 hi byte", 8'hF4, 1'b0, 1'b0);
      sendByte("R4 random", rx, expLow(rx, mAddr, mMask), 1'b0);
      pulseStop();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule